// File: doc/BRIEF.md
# Nonvolatile DAC register controller

This block is the register and sequencing core of a dual-channel voltage DAC with retained settings. Each channel has a working code latch that drives the converter and a retained shadow that holds a set-and-forget value. One retained configuration byte selects the start-up contents of the latches, what a powered-down output does, the device-type address handed to the serial front end, and whether the configuration itself may still be changed or read.

A bus decoder hands the block one request at a time: a channel mask, an operation code, a data word and a commit flag. Loads of an arbitrary code, full scale, zero or mid scale, recall from the shadow and power-down act on the latches in one clock. A committed load and a configuration write also update retained storage and hold the block busy for a programmable write cycle, during which further requests are dropped and flagged. A power-on pulse re-runs the start-up recall with the retained contents kept; the reset input instead restores factory contents.

Top module: `nvdac_ctrl`

## Requirements
- R1: While reset is low, and for one cycle after reset release or after a cycle with `por_i` high, every channel reports power-down (`pd_o` bit = 1) and `busy_o` is 1; in the next cycle each latch takes the start-up value picked by configuration bits [2:1] (00 → 000h, 01 → 3FFh, 10 → 200h, 11 → its shadow) and every `pd_o` bit clears.
- R2: Operation code 0 loads `req_data_i` into each latch whose bit in `req_chan_i` is set (bit 0 = channel 0, occupying `dac_code_o[9:0]`; bit 1 = channel 1, occupying `dac_code_o[19:10]`); other latches keep their code.
- R3: Operation codes 1, 2 and 3 load 3FFh, 000h and 200h respectively into the selected latches.
- R4: Operation code 4 copies each selected channel's shadow into its latch.
- R5: Operation code 5 powers the selected channels down without changing their code; a powered-down channel's `out_mode_o` pair reads 01 (grounded) when configuration bit 3 is 1 and 10 (floating) when it is 0, otherwise 00 (active); any of codes 0 to 4 returns a selected channel to active.
- R6: Code 0 with `req_commit_i` set also writes the data into the shadows of the selected channels (both in one cycle when both are selected) and holds `busy_o` high for exactly WR_CYCLES cycles starting the cycle after acceptance; uncommitted operations leave `busy_o` low.
- R7: Operation code 6 with the configuration unlocked stores `req_data_i[7:0]` as the configuration, starts a write cycle like R6, and `dev_addr_o` always shows configuration bits [7:4].
- R8: With configuration bit 0 set, code 6 is refused (configuration unchanged, no write cycle), `cfg_rd_ok_o` reads 0 and `cfg_rd_data_o` reads 00h; when unlocked they read 1 and the configuration.
- R9: A request presented while `busy_o` is high changes no state and sets `err_o`, which stays set until reset.
- R10: Shadows and configuration keep their contents through `por_i`; reset restores shadows to 000h and the configuration to CFG_DEFAULT (50h).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, restores factory contents |
| por_i | input | 1 | Power-on pulse, restarts the start-up recall |
| req_valid_i | input | 1 | Request strobe, one cycle per request |
| req_op_i | input | 3 | Operation code |
| req_chan_i | input | NUM_CH | Channel select mask |
| req_data_i | input | CODE_W | Code value, or configuration byte in bits [7:0] |
| req_commit_i | input | 1 | Also write retained shadow (code 0 only) |
| dac_code_o | output | NUM_CH*CODE_W | Latch codes, channel 0 in the low bits |
| out_mode_o | output | 2*NUM_CH | Output state per channel: 00 active, 01 grounded, 10 floating |
| pd_o | output | NUM_CH | Power-down indicator per channel |
| busy_o | output | 1 | Start-up or retained write in progress |
| err_o | output | 1 | Sticky flag for requests dropped while busy |
| dev_addr_o | output | 4 | Device-type address for the bus front end |
| cfg_rd_ok_o | output | 1 | Configuration readable (unlocked) |
| cfg_rd_data_o | output | 8 | Configuration byte, zero when locked |

## Verification
The assertions assume requests arrive as single-cycle strobes synchronous to `clk`, that `por_i` is a clean synchronous pulse, and that reset is the only event that clears retained state. The stimulus drives every input on the falling edge, holds each request for exactly one rising edge, and inserts a request inside a running write cycle only on purpose to test the drop path. Power-on pulses are issued only while no write cycle is running, so an aborted retained write is never exercised.

// File: rtl/nvdac_pkg.sv
package nvdac_pkg;

   typedef enum logic [2:0] {
      OP_LOAD   = 3'd0,
      OP_FULL   = 3'd1,
      OP_ZERO   = 3'd2,
      OP_MID    = 3'd3,
      OP_RECALL = 3'd4,
      OP_PDOWN  = 3'd5,
      OP_CFGWR  = 3'd6
   } nvdac_op_e;

   typedef enum logic [1:0] {
      MODE_ACTIVE = 2'b00,
      MODE_GROUND = 2'b01,
      MODE_FLOAT  = 2'b10
   } out_mode_e;

   typedef enum logic [1:0] {
      BOOT_ZERO   = 2'b00,
      BOOT_FULL   = 2'b01,
      BOOT_MID    = 2'b10,
      BOOT_STORED = 2'b11
   } boot_sel_e;

   localparam int CFG_W        = 8;
   localparam int CFG_LOCK_BIT = 0;
   localparam int CFG_BOOT_LO  = 1;
   localparam int CFG_GND_BIT  = 3;
   localparam int CFG_ADDR_LO  = 4;
   localparam int ADDR_W       = 4;

endpackage

// File: rtl/nvdac_wr_timer.sv
module nvdac_wr_timer #(
   parameter int unsigned WR_CYCLES = 250000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic abort_i,
   input  logic start_i,
   output logic busy_o
);
   localparam int CNT_W = (WR_CYCLES > 0) ? $clog2(WR_CYCLES + 1) : 1;

   generate
      if (WR_CYCLES == 0) begin : g_instant
         assign busy_o = 1'b0;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (abort_i)        cnt_q <= '0;
            else if (start_i)        cnt_q <= CNT_W'(WR_CYCLES);
            else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
         end

         assign busy_o = (cnt_q != '0);

         // R6
         cycle_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q != '0 && !start_i && !abort_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
      end
   endgenerate
endmodule

// File: rtl/nvdac_nvstore.sv
module nvdac_nvstore
   import nvdac_pkg::*;
#(
   parameter int              NUM_CH      = 2,
   parameter int              CODE_W      = 10,
   parameter logic [CFG_W-1:0] CFG_DEFAULT = 8'h50
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_CH-1:0]        commit_i,
   input  logic [CODE_W-1:0]        commit_val_i,
   input  logic                     cfg_wr_req_i,
   input  logic [CFG_W-1:0]         cfg_wr_val_i,
   output logic                     cfg_wr_ok_o,
   output logic [CFG_W-1:0]         cfg_o,
   output logic [NUM_CH*CODE_W-1:0] shadow_o
);
   logic [CFG_W-1:0] cfg_q;
   logic             locked;

   assign locked      = cfg_q[CFG_LOCK_BIT];
   assign cfg_wr_ok_o = cfg_wr_req_i && !locked;
   assign cfg_o       = cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cfg_q <= CFG_DEFAULT;
      else if (cfg_wr_ok_o) cfg_q <= cfg_wr_val_i;
   end

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_shadow
         logic [CODE_W-1:0] shd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           shd_q <= '0;
            else if (commit_i[c]) shd_q <= commit_val_i;
         end
         assign shadow_o[c*CODE_W +: CODE_W] = shd_q;

         // R6
         shadow_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            commit_i[c] |=> (shd_q == $past(commit_val_i)));
      end
   endgenerate

   // R8
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && cfg_wr_req_i) |=> $stable(cfg_q));
endmodule

// File: rtl/nvdac_channel.sv
module nvdac_channel
   import nvdac_pkg::*;
#(
   parameter int CODE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pd_force_i,
   input  logic              ld_en_i,
   input  logic [CODE_W-1:0] ld_val_i,
   input  logic              pdn_i,
   input  logic              gnd_mode_i,
   output logic [CODE_W-1:0] code_o,
   output logic              pd_o,
   output logic [1:0]        mode_o
);
   logic [CODE_W-1:0] code_q;
   logic              pd_q;
   out_mode_e         mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         pd_q   <= 1'b1;
      end else if (pd_force_i) begin
         pd_q   <= 1'b1;
      end else if (ld_en_i) begin
         code_q <= ld_val_i;
         pd_q   <= 1'b0;
      end else if (pdn_i) begin
         pd_q   <= 1'b1;
      end
   end

   always_comb begin
      if (!pd_q)           mode = MODE_ACTIVE;
      else if (gnd_mode_i) mode = MODE_GROUND;
      else                 mode = MODE_FLOAT;
   end

   assign code_o = code_q;
   assign pd_o   = pd_q;
   assign mode_o = mode;

   // R5
   pdown_keeps_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pdn_i && !ld_en_i && !pd_force_i) |=> (pd_q && $stable(code_q)));

   // R5
   load_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en_i && !pd_force_i) |=> !pd_q);
endmodule

// File: rtl/nvdac_ctrl.sv
module nvdac_ctrl
   import nvdac_pkg::*;
#(
   parameter int              NUM_CH      = 2,
   parameter int              CODE_W      = 10,
   parameter int unsigned     WR_CYCLES   = 250000,
   parameter logic [CFG_W-1:0] CFG_DEFAULT = 8'h50
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     por_i,
   input  logic                     req_valid_i,
   input  logic [2:0]               req_op_i,
   input  logic [NUM_CH-1:0]        req_chan_i,
   input  logic [CODE_W-1:0]        req_data_i,
   input  logic                     req_commit_i,
   output logic [NUM_CH*CODE_W-1:0] dac_code_o,
   output logic [2*NUM_CH-1:0]      out_mode_o,
   output logic [NUM_CH-1:0]        pd_o,
   output logic                     busy_o,
   output logic                     err_o,
   output logic [ADDR_W-1:0]        dev_addr_o,
   output logic                     cfg_rd_ok_o,
   output logic [CFG_W-1:0]         cfg_rd_data_o
);
   localparam logic [CODE_W-1:0] CODE_FULL = '1;
   localparam logic [CODE_W-1:0] CODE_ZERO = '0;
   localparam logic [CODE_W-1:0] CODE_MID  = CODE_W'(1) << (CODE_W - 1);

   initial begin
      code_width_chk: assert (CODE_W >= CFG_W)
         else $error("CODE_W must hold a configuration byte");
      chan_count_chk: assert (NUM_CH >= 1)
         else $error("NUM_CH must be at least one");
   end

   nvdac_op_e                op;
   logic                     boot_q;
   logic                     err_q;
   logic                     timer_busy;
   logic                     accept;
   logic                     is_level_op;
   logic [NUM_CH-1:0]        commit_ch;
   logic                     cfg_wr_req;
   logic                     cfg_wr_ok;
   logic [CFG_W-1:0]         cfg;
   logic [NUM_CH*CODE_W-1:0] shadow;
   boot_sel_e                boot_sel;
   logic                     wr_start;

   assign op          = nvdac_op_e'(req_op_i);
   assign busy_o      = timer_busy || boot_q;
   assign accept      = req_valid_i && !busy_o && !por_i;
   assign is_level_op = (op == OP_LOAD) || (op == OP_FULL) || (op == OP_ZERO) ||
                        (op == OP_MID)  || (op == OP_RECALL);
   assign cfg_wr_req  = accept && (op == OP_CFGWR);
   assign boot_sel    = boot_sel_e'(cfg[CFG_BOOT_LO +: 2]);
   assign wr_start    = (|commit_ch) || cfg_wr_ok;

   // start-up sequencer: one cycle of forced power-down, then the recall
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      boot_q <= 1'b1;
      else if (por_i)  boot_q <= 1'b1;
      else if (boot_q) boot_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              err_q <= 1'b0;
      else if (req_valid_i && busy_o && !por_i) err_q <= 1'b1;
   end
   assign err_o = err_q;

   nvdac_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .abort_i (por_i),
      .start_i (wr_start),
      .busy_o  (timer_busy)
   );

   nvdac_nvstore #(
      .NUM_CH      (NUM_CH),
      .CODE_W      (CODE_W),
      .CFG_DEFAULT (CFG_DEFAULT)
   ) u_store (
      .clk          (clk),
      .rst_n        (rst_n),
      .commit_i     (commit_ch),
      .commit_val_i (req_data_i),
      .cfg_wr_req_i (cfg_wr_req),
      .cfg_wr_val_i (req_data_i[CFG_W-1:0]),
      .cfg_wr_ok_o  (cfg_wr_ok),
      .cfg_o        (cfg),
      .shadow_o     (shadow)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
         logic              sel;
         logic              ld_en;
         logic              pdn;
         logic [CODE_W-1:0] ld_val;
         logic [CODE_W-1:0] boot_val;
         logic [CODE_W-1:0] req_val;
         logic [CODE_W-1:0] shd;

         assign shd          = shadow[c*CODE_W +: CODE_W];
         assign sel          = accept && req_chan_i[c];
         assign ld_en        = boot_q || (sel && is_level_op);
         assign pdn          = sel && (op == OP_PDOWN);
         assign commit_ch[c] = sel && (op == OP_LOAD) && req_commit_i;

         always_comb begin
            case (boot_sel)
               BOOT_FULL:   boot_val = CODE_FULL;
               BOOT_MID:    boot_val = CODE_MID;
               BOOT_STORED: boot_val = shd;
               default:     boot_val = CODE_ZERO;
            endcase
         end

         always_comb begin
            case (op)
               OP_FULL:   req_val = CODE_FULL;
               OP_ZERO:   req_val = CODE_ZERO;
               OP_MID:    req_val = CODE_MID;
               OP_RECALL: req_val = shd;
               default:   req_val = req_data_i;
            endcase
         end

         assign ld_val = boot_q ? boot_val : req_val;

         nvdac_channel #(.CODE_W(CODE_W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .pd_force_i (por_i),
            .ld_en_i    (ld_en),
            .ld_val_i   (ld_val),
            .pdn_i      (pdn),
            .gnd_mode_i (cfg[CFG_GND_BIT]),
            .code_o     (dac_code_o[c*CODE_W +: CODE_W]),
            .pd_o       (pd_o[c]),
            .mode_o     (out_mode_o[2*c +: 2])
         );
      end
   endgenerate

   assign dev_addr_o    = cfg[CFG_ADDR_LO +: ADDR_W];
   assign cfg_rd_ok_o   = !cfg[CFG_LOCK_BIT];
   assign cfg_rd_data_o = cfg[CFG_LOCK_BIT] ? '0 : cfg;

   // R1
   boot_outputs_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      boot_q |-> (&pd_o));

   // R1
   boot_completes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_q && !por_i) |=> (!boot_q && (pd_o == '0)));

   // R6
   write_holds_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_start && !por_i && (WR_CYCLES > 0)) |=> busy_o);

   // R9
   drop_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && busy_o && !por_i) |=> (err_o && $stable(dac_code_o)));
endmodule

// File: tb/tb_nvdac_ctrl.sv
module tb_nvdac_ctrl;
   import nvdac_pkg::*;

   localparam int WRC = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        por_i = 1'b0;
   logic        req_valid_i = 1'b0;
   logic [2:0]  req_op_i = 3'd0;
   logic [1:0]  req_chan_i = 2'b00;
   logic [9:0]  req_data_i = '0;
   logic        req_commit_i = 1'b0;
   logic [19:0] dac_code_o;
   logic [3:0]  out_mode_o;
   logic [1:0]  pd_o;
   logic        busy_o;
   logic        err_o;
   logic [3:0]  dev_addr_o;
   logic        cfg_rd_ok_o;
   logic [7:0]  cfg_rd_data_o;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   nvdac_ctrl #(.WR_CYCLES(WRC)) dut (
      .clk, .rst_n, .por_i, .req_valid_i, .req_op_i, .req_chan_i,
      .req_data_i, .req_commit_i, .dac_code_o, .out_mode_o, .pd_o,
      .busy_o, .err_o, .dev_addr_o, .cfg_rd_ok_o, .cfg_rd_data_o
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic do_req(input logic [2:0] op, input logic [1:0] ch,
                         input logic [9:0] data, input logic commit);
      @(negedge clk);
      req_valid_i = 1'b1; req_op_i = op; req_chan_i = ch;
      req_data_i = data; req_commit_i = commit;
      @(negedge clk);
      req_valid_i = 1'b0; req_commit_i = 1'b0;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (busy_o && n < 200) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic power_pulse;
      @(negedge clk); por_i = 1'b1;
      @(negedge clk); por_i = 1'b0;
      check("R1", "pd during boot", pd_o, 2'b11);
      check("R1", "busy during boot", busy_o, 1);
      @(negedge clk);
      check("R1", "pd after boot", pd_o, 2'b00);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R1", "pd in reset", pd_o, 2'b11);
      check("R1", "busy in reset", busy_o, 1);
      check("R1", "codes in reset", dac_code_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "boot zero codes", dac_code_o, 0);
      check("R1", "pd after release", pd_o, 2'b00);
      check("R10", "default cfg", cfg_rd_data_o, 8'h50);
      check("R7", "default address", dev_addr_o, 4'h5);
      check("R8", "unlocked read ok", cfg_rd_ok_o, 1);
      check("R9", "err clear", err_o, 0);
   endtask

   task automatic t_load;
      do_req(OP_LOAD, 2'b01, 10'h155, 1'b0);
      check("R2", "ch0 load", dac_code_o, {10'h000, 10'h155});
      check("R6", "no busy uncommitted", busy_o, 0);
      do_req(OP_LOAD, 2'b10, 10'h2AA, 1'b0);
      check("R2", "ch1 load", dac_code_o, {10'h2AA, 10'h155});
   endtask

   task automatic t_scale;
      do_req(OP_FULL, 2'b11, 10'h000, 1'b0);
      check("R3", "full both", dac_code_o, {10'h3FF, 10'h3FF});
      do_req(OP_ZERO, 2'b01, 10'h000, 1'b0);
      do_req(OP_MID, 2'b10, 10'h000, 1'b0);
      check("R3", "zero ch0 mid ch1", dac_code_o, {10'h200, 10'h000});
   endtask

   task automatic t_pdown;
      do_req(OP_PDOWN, 2'b01, 10'h000, 1'b0);
      check("R5", "pd flag ch0", pd_o, 2'b01);
      check("R5", "float mode", out_mode_o, 4'b0010);
      check("R5", "code kept", dac_code_o, {10'h200, 10'h000});
      do_req(OP_LOAD, 2'b01, 10'h123, 1'b0);
      check("R5", "load wakes", pd_o, 2'b00);
      check("R5", "active mode", out_mode_o, 4'b0000);
   endtask

   task automatic t_commit;
      int n;
      do_req(OP_LOAD, 2'b11, 10'h2C3, 1'b1);
      n = 0;
      while (busy_o && n < 200) begin
         if (n == 5) begin
            req_valid_i = 1'b1; req_op_i = OP_LOAD; req_chan_i = 2'b01;
            req_data_i = 10'h001;
         end else begin
            req_valid_i = 1'b0;
         end
         @(negedge clk);
         n++;
      end
      req_valid_i = 1'b0;
      check("R6", "busy length", n, WRC);
      check("R9", "dropped load", dac_code_o, {10'h2C3, 10'h2C3});
      check("R9", "err sticky", err_o, 1);
      do_req(OP_ZERO, 2'b11, 10'h000, 1'b0);
      do_req(OP_RECALL, 2'b11, 10'h000, 1'b0);
      check("R4", "recall both", dac_code_o, {10'h2C3, 10'h2C3});
      do_req(OP_LOAD, 2'b01, 10'h0F0, 1'b1);
      wait_idle(n);
      check("R6", "busy length single", n, WRC);
      do_req(OP_ZERO, 2'b11, 10'h000, 1'b0);
      do_req(OP_RECALL, 2'b11, 10'h000, 1'b0);
      check("R6", "single commit", dac_code_o, {10'h2C3, 10'h0F0});
   endtask

   task automatic t_cfg;
      int n;
      do_req(OP_CFGWR, 2'b00, 10'h03E, 1'b0);
      check("R7", "cfg written", cfg_rd_data_o, 8'h3E);
      wait_idle(n);
      check("R7", "cfg busy length", n, WRC);
      check("R7", "new address", dev_addr_o, 4'h3);
      do_req(OP_PDOWN, 2'b10, 10'h000, 1'b0);
      check("R5", "ground mode", out_mode_o, 4'b0100);
      do_req(OP_ZERO, 2'b11, 10'h000, 1'b0);
      power_pulse();
      check("R1", "stored boot", dac_code_o, {10'h2C3, 10'h0F0});
      check("R10", "cfg kept", cfg_rd_data_o, 8'h3E);
      do_req(OP_CFGWR, 2'b00, 10'h03C, 1'b0);
      wait_idle(n);
      power_pulse();
      check("R1", "mid boot", dac_code_o, {10'h200, 10'h200});
   endtask

   task automatic t_lock;
      int n;
      do_req(OP_CFGWR, 2'b00, 10'h03B, 1'b0);
      wait_idle(n);
      check("R8", "locked read ok", cfg_rd_ok_o, 0);
      check("R8", "locked read data", cfg_rd_data_o, 8'h00);
      do_req(OP_CFGWR, 2'b00, 10'h050, 1'b0);
      check("R8", "refused no busy", busy_o, 0);
      check("R8", "address unchanged", dev_addr_o, 4'h3);
      power_pulse();
      check("R8", "cfg unchanged full boot", dac_code_o, {10'h3FF, 10'h3FF});
   endtask

   task automatic t_factory;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10", "cfg restored", cfg_rd_data_o, 8'h50);
      check("R9", "err cleared", err_o, 0);
      do_req(OP_RECALL, 2'b11, 10'h000, 1'b0);
      check("R10", "shadow cleared", dac_code_o, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_load();
      t_scale();
      t_pdown();
      t_commit();
      t_cfg();
      t_lock();
      t_factory();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule